// File: doc/BRIEF.md
# DDR Command Bus Bank and Power-State Tracker

The tracker sits beside a DDR SDRAM controller and listens to the command bus the controller drives. On every rising clock edge it takes in the chip select, the three active-low command strobes, the bank-select bits, the address bus and the clock enable. From these it keeps a copy of the memory's state: which banks hold an open row, and which row that is. It also reports the power condition of the device: idle, active, precharge power-down, active power-down or self refresh.

Two error pulses come out of the block. One flags commands that break the bank protocol: an activate to a bank that is already open, or an access to a closed bank. The other flags clock enable dropping while a read or write burst is still running. A mode-register write is reported as a one-cycle pulse, split by which register the bank bits select. Other blocks use the outputs for command legality checks, debug visibility and power accounting. The block never drives the bus.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: While reset is asserted, and until the first accepted command afterwards, every bank reads closed, `pmode` reads 0 (idle), and `proto_err`, `cke_err`, `mr_base_wr` and `mr_ext_wr` are low.
- R2: A cycle in which `cs_n` is sampled high has no effect on bank state, rows or mode-register pulses, whatever the three strobes carry.
- R3: The strobes `{ras_n,cas_n,we_n}` encode 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register write, and 111 or 110 no operation. A command is acted on only when clock enable was sampled high at the previous edge and the device is not in power-down or self refresh.
- R4: An activate to a closed bank sets `bank_open[ba]` in the next cycle and records `addr` in that bank's slice `open_row[ba*13 +: 13]`.
- R5: A precharge with `addr[10]` low closes only the bank given by `ba`. With `addr[10]` high it closes every bank. Both take effect in the next cycle.
- R6: A legal read or write with `addr[10]` high closes the accessed bank in the next cycle. With `addr[10]` low the bank stays open.
- R7: An activate to an open bank, or a read or write to a closed bank, raises `proto_err` for one cycle and leaves all bank state unchanged.
- R8: `pmode` is 0 idle or 1 active (any bank open) in normal operation. Clock enable sampled falling enters 2 (precharge power-down) if all banks were closed, or 3 (active power-down) otherwise. Clock enable sampled high at a later edge returns to normal operation.
- R9: A refresh accepted at an edge where clock enable is sampled falling enters self refresh, so `pmode` reads 4. Raising clock enable makes `pmode` read 0 at once, without waiting for a clock edge.
- R10: After a legal read or write, `cke_err` pulses in the cycle after any of the edges from the command's edge through the next 3 (4 edges in all) at which clock enable is sampled low.
- R11: An accepted mode-register write pulses `mr_base_wr` when `ba` is 0 and `mr_ext_wr` when `ba` is 1, for one cycle. Other `ba` values pulse neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cke | input | 1 | Sampled clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column or opcode bus; bit 10 is the precharge/auto-close flag |
| bank_open | output | 4 | One open flag per bank |
| open_row | output | 52 | Open row per bank, 13 bits each, bank 0 in the low bits |
| pmode | output | 3 | Power mode code (0 idle, 1 active, 2 precharge power-down, 3 active power-down, 4 self refresh) |
| proto_err | output | 1 | Pulse: bank protocol violation |
| cke_err | output | 1 | Pulse: clock enable low during an access |
| mr_base_wr | output | 1 | Pulse: base mode register written |
| mr_ext_wr | output | 1 | Pulse: extended mode register written |

## Verification
A wrong bank flag shows up on `bank_open` one cycle after the command that caused it. It also shows up later as a false or missing `proto_err`, and as the wrong choice between the two power-down codes at the next clock-enable fall. A lost access window shows only as a missing `cke_err`, and only when clock enable drops inside the following four edges. The bench therefore drops it on the edge just after a read. A stuck power state shows on `pmode` in the first cycle after the edge that should have moved it. In self refresh it also shows between edges, because the exit does not wait for the clock.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    PM_IDLE   = 3'd0,
    PM_ACTIVE = 3'd1,
    PM_PPD    = 3'd2,
    PM_APD    = 3'd3,
    PM_SREF   = 3'd4
  } pmode_e;

  typedef enum logic [1:0] {
    PS_NORM,
    PS_PPD,
    PS_APD,
    PS_SREF
  } pstate_e;

endpackage

// File: rtl/ddr_trk_decode.sv
module ddr_trk_decode
  import ddr_trk_pkg::*;
#(
  parameter int BAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [BAW-1:0] ba,
  input  logic           cmd_ok,
  output cmd_e           cmd,
  output logic           mr_base_wr,
  output logic           mr_ext_wr
);

  logic mr_base_d, mr_ext_d;
  logic mr_base_q, mr_ext_q;

  // strobe decode; chip select is applied through cmd_ok
  always_comb begin
    unique case ({ras_n, cas_n, we_n})
      3'b011:  cmd = CMD_ACT;
      3'b101:  cmd = CMD_RD;
      3'b100:  cmd = CMD_WR;
      3'b010:  cmd = CMD_PRE;
      3'b001:  cmd = CMD_REF;
      3'b000:  cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    mr_base_d = cmd_ok && (cmd == CMD_MRS) && (ba == BAW'(0));
    mr_ext_d  = cmd_ok && (cmd == CMD_MRS) && (ba == BAW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_base_q <= 1'b0;
      mr_ext_q  <= 1'b0;
    end else begin
      mr_base_q <= mr_base_d;
      mr_ext_q  <= mr_ext_d;
    end
  end

  assign mr_base_wr = mr_base_q;
  assign mr_ext_wr  = mr_ext_q;

  // R11: the two selects never pulse together
  a_r11_mr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mr_base_q && mr_ext_q));

endmodule

// File: rtl/ddr_trk_banks.sv
module ddr_trk_banks
  import ddr_trk_pkg::*;
#(
  parameter int NB     = 4,
  parameter int AW     = 13,
  parameter int AP_BIT = 10,
  parameter int BAW    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_ok,
  input  cmd_e                   cmd,
  input  logic [BAW-1:0]         ba,
  input  logic [AW-1:0]          addr,
  output logic [NB-1:0]          open_q,
  output logic [NB-1:0][AW-1:0]  row_q,
  output logic                   any_open,
  output logic                   acc_start,
  output logic                   proto_err
);

  logic [NB-1:0]         open_d;
  logic [NB-1:0][AW-1:0] row_d;
  logic                  sel_open;
  logic                  is_rw;
  logic                  proto_d;
  logic                  proto_q;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic          hit;
    logic          o_d;
    logic [AW-1:0] r_d;

    assign hit = (ba == BAW'(i));

    always_comb begin
      o_d = open_q[i];
      r_d = row_q[i];
      if (cmd_ok) begin
        unique case (cmd)
          CMD_ACT: if (hit && !open_q[i]) begin
            o_d = 1'b1;
            r_d = addr;
          end
          CMD_RD, CMD_WR: if (hit && open_q[i] && addr[AP_BIT]) o_d = 1'b0;
          CMD_PRE: if (hit || addr[AP_BIT]) o_d = 1'b0;
          default: ;
        endcase
      end
    end

    assign open_d[i] = o_d;
    assign row_d[i]  = r_d;
  end

  always_comb begin
    sel_open  = open_q[ba];
    is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
    acc_start = cmd_ok && is_rw && sel_open;
    proto_d   = cmd_ok && (((cmd == CMD_ACT) && sel_open) || (is_rw && !sel_open));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= '0;
      row_q   <= '0;
      proto_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      row_q   <= row_d;
      proto_q <= proto_d;
    end
  end

  assign any_open  = |open_q;
  assign proto_err = proto_q;

  // R2: no accepted command, no bank change
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok |=> $stable(open_q));

  // R4: activate to a closed bank opens it with the given row
  a_r4_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && cmd == CMD_ACT && !open_q[ba])
      |=> (open_q[$past(ba)] && row_q[$past(ba)] == $past(addr)));

  // R7: a flagged command left the open flags as they were
  a_r7_proto_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    proto_q |-> (open_q == $past(open_q)));

  // R5: precharge-all empties every bank
  a_r5_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && cmd == CMD_PRE && addr[AP_BIT]) |=> (open_q == '0));

endmodule

// File: rtl/ddr_trk_power.sv
module ddr_trk_power
  import ddr_trk_pkg::*;
#(
  parameter int ACC_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cke,
  input  logic   cs_n,
  input  cmd_e   cmd,
  input  logic   any_open,
  input  logic   acc_start,
  output logic   cmd_ok,
  output pmode_e pmode,
  output logic   cke_err
);

  localparam int CW = $clog2(ACC_CYC + 1);

  pstate_e       st_q, st_d;
  logic          cke_q;
  logic [CW-1:0] acc_q, acc_d;
  logic          busy;
  logic          cke_err_d, cke_err_q;

  assign cmd_ok = (st_q == PS_NORM) && cke_q && !cs_n;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_NORM: if (cke_q && !cke) begin
        if (cmd_ok && cmd == CMD_REF) st_d = PS_SREF;
        else if (any_open)            st_d = PS_APD;
        else                          st_d = PS_PPD;
      end
      PS_PPD, PS_APD, PS_SREF: if (cke) st_d = PS_NORM;
      default: st_d = PS_NORM;
    endcase
  end

  always_comb begin
    busy      = acc_start || (acc_q != '0);
    cke_err_d = busy && !cke;
    if (acc_start)          acc_d = CW'(ACC_CYC - 1);
    else if (acc_q != '0)   acc_d = acc_q - CW'(1);
    else                    acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PS_NORM;
      cke_q     <= 1'b0;
      acc_q     <= '0;
      cke_err_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cke_q     <= cke;
      acc_q     <= acc_d;
      cke_err_q <= cke_err_d;
    end
  end

  // self-refresh exit follows the clock-enable pin with no clock edge
  always_comb begin
    unique case (st_q)
      PS_PPD:  pmode = PM_PPD;
      PS_APD:  pmode = PM_APD;
      PS_SREF: pmode = cke ? PM_IDLE : PM_SREF;
      default: pmode = any_open ? PM_ACTIVE : PM_IDLE;
    endcase
  end

  assign cke_err = cke_err_q;

  // R8: falling clock enable with all banks closed enters precharge power-down
  a_r8_ppd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_NORM && cke_q && !cke && !any_open && !(cmd_ok && cmd == CMD_REF))
      |=> (pmode == PM_PPD));

  // R9: refresh with clock enable falling lands in self refresh
  a_r9_sref_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && cmd == CMD_REF && !cke) |=> (st_q == PS_SREF));

  // R10: clock enable low inside an access window is reported
  a_r10_cke_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cke) |=> cke_err);

  // R3: nothing is accepted while powered down
  a_r3_no_cmd_when_down: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PS_NORM) |-> !cmd_ok);

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NB      = 4,
  parameter int AW      = 13,
  parameter int AP_BIT  = 10,
  parameter int ACC_CYC = 4,
  localparam int BAW    = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BAW-1:0]    ba,
  input  logic [AW-1:0]     addr,
  output logic [NB-1:0]     bank_open,
  output logic [NB*AW-1:0]  open_row,
  output logic [2:0]        pmode,
  output logic              proto_err,
  output logic              cke_err,
  output logic              mr_base_wr,
  output logic              mr_ext_wr
);

  logic [1:0]            rst_sync;
  logic                  rst_int_n;
  cmd_e                  cmd;
  logic                  cmd_ok;
  logic                  any_open;
  logic                  acc_start;
  logic [NB-1:0][AW-1:0] row_q;
  pmode_e                pmode_int;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ddr_trk_decode #(.BAW(BAW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .cmd_ok     (cmd_ok),
    .cmd        (cmd),
    .mr_base_wr (mr_base_wr),
    .mr_ext_wr  (mr_ext_wr)
  );

  ddr_trk_banks #(.NB(NB), .AW(AW), .AP_BIT(AP_BIT), .BAW(BAW)) u_banks (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_ok    (cmd_ok),
    .cmd       (cmd),
    .ba        (ba),
    .addr      (addr),
    .open_q    (bank_open),
    .row_q     (row_q),
    .any_open  (any_open),
    .acc_start (acc_start),
    .proto_err (proto_err)
  );

  ddr_trk_power #(.ACC_CYC(ACC_CYC)) u_pwr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .cmd       (cmd),
    .any_open  (any_open),
    .acc_start (acc_start),
    .cmd_ok    (cmd_ok),
    .pmode     (pmode_int),
    .cke_err   (cke_err)
  );

  assign open_row = row_q;
  assign pmode    = pmode_int;

endmodule

// File: tb/ddr_cmd_tracker_test.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_test;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                         C_NOP = 3'b111, C_BST = 3'b110;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  bank_open;
  logic [51:0] open_row;
  logic [2:0]  pmode;
  logic        proto_err, cke_err, mr_base_wr, mr_ext_wr;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int          m_st;    // 0 normal, 1 ppd, 2 apd, 3 self refresh
  bit          m_ckeq;
  bit          m_open [4];
  logic [12:0] m_row [4];
  int          m_acc;
  bit          m_perr, m_cerr, m_mb, m_me;

  always #4 clk = ~clk;

  ddr_cmd_tracker uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
    .open_row(open_row), .pmode(pmode), .proto_err(proto_err),
    .cke_err(cke_err), .mr_base_wr(mr_base_wr), .mr_ext_wr(mr_ext_wr)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_pmode();
    bit any = 0;
    for (int i = 0; i < 4; i++) any |= m_open[i];
    case (m_st)
      1: return 2;
      2: return 3;
      3: return cke ? 0 : 4;
      default: return any ? 1 : 0;
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_ckeq = 0; m_acc = 0;
    m_perr = 0; m_cerr = 0; m_mb = 0; m_me = 0;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = '0; end
  endtask

  task automatic model_step();
    bit ok, any_pre, start;
    logic [2:0] c;
    c = {ras_n, cas_n, we_n};
    ok = (m_st == 0) && m_ckeq && !cs_n;
    any_pre = 0;
    for (int i = 0; i < 4; i++) any_pre |= m_open[i];
    m_perr = 0; m_mb = 0; m_me = 0; start = 0;
    if (ok) begin
      case (c)
        C_ACT: if (m_open[ba]) m_perr = 1;
               else begin m_open[ba] = 1; m_row[ba] = addr; end
        C_RD, C_WR: if (!m_open[ba]) m_perr = 1;
                    else begin start = 1; if (addr[10]) m_open[ba] = 0; end
        C_PRE: if (addr[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
               else m_open[ba] = 0;
        C_MRS: begin m_mb = (ba == 0); m_me = (ba == 1); end
        default: ;
      endcase
    end
    m_cerr = (start || m_acc != 0) && !cke;
    if (start) m_acc = 3;
    else if (m_acc > 0) m_acc--;
    if (m_st == 0) begin
      if (m_ckeq && !cke) m_st = (ok && c == C_REF) ? 3 : (any_pre ? 2 : 1);
    end else if (cke) m_st = 0;
    m_ckeq = cke;
  endtask

  task automatic compare(string tag);
    chk(tag, "bank_open", bank_open,
        {m_open[3], m_open[2], m_open[1], m_open[0]});
    for (int i = 0; i < 4; i++)
      if (m_open[i]) chk(tag, "open_row", open_row[i*13 +: 13], m_row[i]);
    chk(tag, "pmode", pmode, exp_pmode());
    chk(tag, "proto_err", proto_err, m_perr);
    chk(tag, "cke_err", cke_err, m_cerr);
    chk(tag, "mr_base_wr", mr_base_wr, m_mb);
    chk(tag, "mr_ext_wr", mr_ext_wr, m_me);
  endtask

  task automatic cyc(string tag, logic k, logic c_n, logic [2:0] c,
                     logic [1:0] b, logic [12:0] a);
    @(negedge clk);
    cke = k; cs_n = c_n; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk);
    model_step();
    #1 compare(tag);
  endtask

  task automatic nop(string tag, logic k, int n);
    for (int i = 0; i < n; i++) cyc(tag, k, 1'b0, C_NOP, 2'd0, 13'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
    ba = '0; addr = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: state under reset
    chk("R1", "bank_open", bank_open, 0);
    chk("R1", "pmode", pmode, 0);
    chk("R1", "errors", {proto_err, cke_err, mr_base_wr, mr_ext_wr}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1");

    // R3: commands with clock enable low at previous edge are not taken
    cyc("R3", 1'b1, 1'b0, C_ACT, 2'd1, 13'h0123);
    nop("R3", 1'b1, 2);

    // R4: activates record rows
    cyc("R4", 1'b1, 1'b0, C_ACT, 2'd0, 13'h1ABC);
    cyc("R4", 1'b1, 1'b0, C_ACT, 2'd2, 13'h0055);
    // R7: activate to an open bank, read of a closed bank
    cyc("R7", 1'b1, 1'b0, C_ACT, 2'd0, 13'h0F0F);
    cyc("R7", 1'b1, 1'b0, C_RD,  2'd1, 13'h0000);
    cyc("R7", 1'b1, 1'b0, C_WR,  2'd3, 13'h0400);
    // R2: deselected activate, precharge-all and mode write
    cyc("R2", 1'b1, 1'b1, C_ACT, 2'd1, 13'h1111);
    cyc("R2", 1'b1, 1'b1, C_PRE, 2'd0, 13'h0400);
    cyc("R2", 1'b1, 1'b1, C_MRS, 2'd0, 13'h0000);

    // R6: read without auto-close, write with auto-close
    cyc("R6", 1'b1, 1'b0, C_RD, 2'd0, 13'h0010);
    nop("R6", 1'b1, 4);
    cyc("R6", 1'b1, 1'b0, C_WR, 2'd2, 13'h0408);
    nop("R6", 1'b1, 4);

    // R5: single-bank and all-bank precharge
    cyc("R5", 1'b1, 1'b0, C_PRE, 2'd0, 13'h0000);
    cyc("R5", 1'b1, 1'b0, C_ACT, 2'd1, 13'h1FFF);
    cyc("R5", 1'b1, 1'b0, C_ACT, 2'd3, 13'h0001);
    cyc("R5", 1'b1, 1'b0, C_PRE, 2'd1, 13'h0000);
    cyc("R5", 1'b1, 1'b0, C_ACT, 2'd2, 13'h0AAA);
    cyc("R5", 1'b1, 1'b0, C_PRE, 2'd0, 13'h0400);

    // R11: mode-register selects
    cyc("R11", 1'b1, 1'b0, C_MRS, 2'd0, 13'h0032);
    cyc("R11", 1'b1, 1'b0, C_MRS, 2'd1, 13'h0002);
    cyc("R11", 1'b1, 1'b0, C_MRS, 2'd2, 13'h0000);
    cyc("R3", 1'b1, 1'b0, C_BST, 2'd0, 13'h0000);

    // R8: precharge power-down, commands ignored inside, exit
    nop("R8", 1'b0, 1);
    cyc("R3", 1'b0, 1'b0, C_ACT, 2'd0, 13'h0222);
    cyc("R8", 1'b1, 1'b0, C_ACT, 2'd0, 13'h0333);
    nop("R8", 1'b1, 1);
    cyc("R8", 1'b1, 1'b0, C_ACT, 2'd1, 13'h0444);
    // R8: active power-down
    nop("R8", 1'b0, 3);
    nop("R8", 1'b1, 2);

    // R10: clock enable dropped one edge after a read
    cyc("R10", 1'b1, 1'b0, C_RD, 2'd1, 13'h0020);
    nop("R10", 1'b0, 2);
    nop("R10", 1'b1, 5);
    // R10: window ended, no error
    cyc("R10", 1'b1, 1'b0, C_WR, 2'd1, 13'h0000);
    nop("R10", 1'b1, 4);
    nop("R10", 1'b0, 1);
    nop("R10", 1'b1, 2);

    // R9: self refresh entry and clockless exit
    cyc("R9", 1'b1, 1'b0, C_PRE, 2'd0, 13'h0400);
    cyc("R9", 1'b0, 1'b0, C_REF, 2'd0, 13'h0000);
    nop("R9", 1'b0, 3);
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b1;
    #1 chk("R9", "pmode async exit", pmode, 0);
    @(posedge clk);
    model_step();
    #1 compare("R9");
    nop("R9", 1'b1, 2);
    cyc("R9", 1'b1, 1'b0, C_ACT, 2'd3, 13'h1234);
    nop("R9", 1'b1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule